// File: doc/BRIEF.md
# Nibble-Sequenced Fractional Clock Divider

This block derives a slow backup clock, around 32 kHz, from a faster RTC clock whose frequency is not a whole multiple of the target. A 32-bit factor word holds eight 4-bit half-period lengths. The divider plays these lengths in rotation, so the output period may vary by one RTC cycle from one half to the next. The average output frequency then matches the wanted non-integer ratio.

The factor is built outside the block. Take M as the RTC frequency in kHz divided by 64. Every component is then M or M+1, and the longer ones come first, starting at the lowest nibble. The eight components add up to the RTC frequency in kHz times 4/32, so one full rotation covers four output periods. The block itself only counts cycles. It does not measure the RTC clock or compute the factor.

Top module: `nib_frac_div`

## Requirements
- R1: While reset is asserted, and on the first sample after reset, `clk_out` is low.
- R2: Component n sits in `factor` bits 4n+3:4n, so x0 is bits 3:0 and x7 is bits 31:28. The n-th half-period of a rotation lasts exactly x_n RTC cycles.
- R3: The first half-period after `en` rises is low. `clk_out` toggles at the end of every half-period.
- R4: After half-period x7 the sequence returns to x0 and keeps running.
- R5: A component value of 0 gives a half-period of one RTC cycle, so the output never stalls.
- R6: A new `factor` value applied while the divider runs is used only from the next return to x0. The current rotation finishes with the old value.
- R7: While `en` is low, `clk_out` is low from the next cycle on and the sequence goes back to x0. Enabling again starts with a low half-period of length x0.
- R8: One full rotation of eight half-periods holds exactly four rising edges of `clk_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Divider run enable |
| factor | input | 32 | Eight packed 4-bit half-period lengths, x0 in the low nibble |
| clk_out | output | 1 | Divided backup clock |

## Verification
The bench records the length of every half-period in RTC cycles over two rotations for each of several factors:
- A uniform factor, which shows the divider cycling at all.
- Mixed M/M+1 words with the long nibbles first, which show the nibble order and the wrap.
- A descending all-distinct word, which catches any misindexed nibble.
- A word with zero nibbles, which checks the one-cycle floor.

A directed run changes the factor mid-rotation to check that the change waits for the wrap. Another drops the enable to check the held-low output and the restart from x0.

// File: rtl/nib_frac_div.sv
module nib_frac_div #(
  parameter int SEGS  = 8,
  parameter int NIB_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [SEGS*NIB_W-1:0] factor,
  output logic                  clk_out
);
  localparam int FW = SEGS * NIB_W;
  localparam int IW = (SEGS > 1) ? $clog2(SEGS) : 1;

  logic [FW-1:0]    act;
  logic [IW-1:0]    idx;
  logic [NIB_W-1:0] cnt;
  logic             out_q;
  logic [NIB_W-1:0] nib, seg_len;
  logic             seg_end, last_seg;

  assign nib      = act[int'(idx)*NIB_W +: NIB_W];
  assign seg_len  = (nib == '0) ? NIB_W'(1) : nib;
  assign seg_end  = (cnt == seg_len - NIB_W'(1));
  assign last_seg = (idx == IW'(SEGS-1));
  assign clk_out  = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= '0;
      idx   <= '0;
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (!en) begin
      act   <= factor;
      idx   <= '0;
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (seg_end) begin
      cnt   <= '0;
      out_q <= ~out_q;
      if (last_seg) begin
        idx <= '0;
        act <= factor;
      end else begin
        idx <= idx + IW'(1);
      end
    end else begin
      cnt <= cnt + NIB_W'(1);
    end
  end

  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !clk_out);

  // R3
  toggle_at_seg_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (clk_out != $past(clk_out))) |-> (cnt == '0));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (clk_out != $past(clk_out))) |->
      (idx == (($past(idx) == IW'(SEGS-1)) ? IW'(0) : $past(idx) + IW'(1))));

  // R6
  factor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (idx != '0)) |-> $stable(act));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < seg_len));
endmodule

// File: tb/sim_nib_frac_div.sv
`timescale 1ns/1ps
module sim_nib_frac_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] factor = '0;
  logic        clk_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nib_frac_div u0 (.clk(clk), .rst_n(rst_n), .en(en), .factor(factor), .clk_out(clk_out));

  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'h4444_4444, 32'h4444_5555, 32'h3333_3444,
    32'hFEDC_BA98, 32'h2020_0102, 32'h1111_1111
  };

  function automatic int exp_len(input logic [31:0] f, input int n);
    int v;
    v = int'(f[4*n +: 4]);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Enable with fa, measure nruns half-periods; after sw runs (sw>0) apply fb.
  task automatic run_seq(input logic [31:0] fa, input logic [31:0] fb, input int sw,
                         input int nruns, input string req);
    int run, r, rises;
    logic lvl;
    logic [31:0] f;
    @(negedge clk);
    factor = fa;
    @(negedge clk);
    en = 1'b1;
    chk(clk_out == 1'b0, {req, " R3 first half low"}, clk_out, 0);
    lvl = clk_out; run = 1; r = 0; rises = 0;
    while (r < nruns) begin
      @(negedge clk);
      if (clk_out == lvl) run++;
      else begin
        f = (sw > 0 && r >= 8) ? fb : fa;
        chk(run == exp_len(f, r % 8), {req, " R2 half-period length"}, run, exp_len(f, r % 8));
        if (clk_out) rises++;
        if (r == 7) chk(rises == 4, "R8 rising edges per rotation", rises, 4);
        r++;
        if (sw > 0 && r == sw) factor = fb;
        lvl = clk_out; run = 1;
      end
    end
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(clk_out == 1'b0, "R7 held low while disabled", clk_out, 0);
    end
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(clk_out == 1'b0, "R1 low in reset", clk_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_out == 1'b0, "R1 low after reset", clk_out, 0);

    for (int i = 0; i < NV; i++)
      run_seq(VEC[i], VEC[i], 0, 16, "R4 table");

    // R5 all-zero factor: every half-period one cycle
    run_seq(32'h0000_0000, 32'h0, 0, 16, "R5 zero nibbles");

    // R6 mid-rotation factor change waits for wrap
    run_seq(32'h3333_3333, 32'h2222_2222, 3, 16, "R6 change at wrap");

    // R7 disable mid-segment and restart from x0
    @(negedge clk);
    factor = 32'h1234_5679;
    en = 1'b1;
    repeat (13) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(clk_out == 1'b0, "R7 low next cycle after disable", clk_out, 0);
    run_seq(32'h1234_5679, 32'h1234_5679, 0, 8, "R7 restart at x0");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule